// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from five edge-sensitive external pins, a bank of eight key pins, eleven single-cycle peripheral event strobes and a software break strobe. Each of fifteen maskable slots has a request latch and an enable bit. A global interrupt-disable flag gates the maskable slots, and a fixed priority resolves requests that are pending together. The winning request goes to the CPU as a 16-bit vector address, held on `vec_o` while `irq_o` is high, until the CPU answers with a one-cycle `ack_i` strobe.

Two slots are shared. Slot 2 takes either the INT2 pin or the falling edge of the AND of the key pins. Slot 13 takes either the timer-Y strobe or the CNTR1 pin. A configuration bit picks the source of each shared slot. Edge detection works on a level that already includes the edge select and the source select. Changing either setting can therefore latch a request on its own, the same way a real pin edge does. A small register port gives access to the enables, the requests, the configuration and the disable flag.

Top module: `icu_vec_ctrl`

## Requirements
- R1: After reset the enables, requests and configuration read 0, the disable flag reads 1, and `irq_o` is 1 with `vec_o`=0xFFFC until the first acknowledge.
- R2: A maskable slot k is presented only when its request bit, its enable bit (register 0, bit k) are 1 and the disable flag (register 3, bit 0) is 0.
- R3: Writing register 1 clears each request bit written 0 and leaves each bit written 1 unchanged. No write ever sets a request bit.
- R4: Among presentable slots the lowest index wins, with vector 0xFFFA-2k. The others stay latched and are presented after later acknowledges.
- R5: A `brk_i` strobe is taken whatever the flag and enables are, at the lowest priority, with vector 0xFFDC.
- R6: In the cycle after an `ack_i` while `irq_o` is 1, `irq_o` is 0, the accepted request bit is 0 and the disable flag is 1.
- R7: While `irq_o` is 1 and no acknowledge comes, `irq_o` and `vec_o` do not change.
- R8: External pins (bit 0 INT0, 1 INT1, 2 INT2, 3 CNTR0, 4 CNTR1) pass a 2-flop synchronizer. Register 2 bit i set to 1 selects the rising edge and 0 the falling edge. INT0, INT1 and CNTR0 set slots 0, 1 and 12.
- R9: With register 2 bit 8 at 0, slot 2 follows the INT2 edge. With it at 1, slot 2 latches on the falling edge of the AND of all key pins, and INT2 is ignored.
- R10: With register 2 bit 9 at 0, slot 13 latches on `periph_evt_i[9]` (timer Y). With it at 1, slot 13 latches on the CNTR1 edge, and the strobe is ignored.
- R11: A change of an edge-select or source-select bit latches a request when the newly selected source is already at its active level. Examples are a switch to falling while the pin is low, or a switch to key input while the key AND is low.
- R12: `periph_evt_i[0..8]` set slots 3..11 (serial 1 rx/tx, serial 2 rx/tx, timer X, timers 1-4), and `periph_evt_i[10]` sets slot 14 (A-D done).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin_i | input | 5 | Asynchronous external pins INT0, INT1, INT2, CNTR0, CNTR1 |
| key_pin_i | input | 8 | Asynchronous key-input pins |
| periph_evt_i | input | 11 | Single-cycle peripheral event strobes |
| brk_i | input | 1 | Software break strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 enable, 1 request, 2 config, 3 flag |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 16 | Vector low address of the presented interrupt |
| ack_i | input | 1 | One-cycle acknowledge from the CPU |

## Verification
Random bursts of simultaneous peripheral strobes against random enable masks test the priority order. Each acknowledge should present the next-lowest enabled slot, and disabled requests should stay latched. Requests arriving while the disable flag is set tell the enable and flag gating apart from the latching itself. Directed pin sequences try each edge polarity and both settings of each shared-slot select, with the opposite source toggled, to show that the ignored source leaves the request register untouched. Writes to the configuration with a pin already low or high show whether a setting change counts as an edge. Break strobes, sent alone and together with a maskable request, show the unmaskable lowest-priority path.

// File: rtl/icu_pkg.sv
// Shared constants for the vectored interrupt controller.
// Codes: 0 = reset, 1..N_SLOT = maskable slot (code-1), N_SLOT+1 = break.
package icu_pkg;
    localparam int N_SLOT   = 15;
    localparam int N_EXT    = 5;
    localparam int N_PERIPH = 11;
    localparam int CODE_W   = $clog2(N_SLOT + 2);
    localparam int VEC_W    = 16;

    localparam logic [CODE_W-1:0] CODE_RESET = '0;
    localparam logic [CODE_W-1:0] CODE_BRK   = CODE_W'(N_SLOT + 1);
    localparam logic [VEC_W-1:0]  VEC_TOP    = 16'hFFFC;

    // external pin order
    localparam int EX_INT0 = 0, EX_INT1 = 1, EX_INT2 = 2, EX_CNTR0 = 3, EX_CNTR1 = 4;
    // slot indices that are not a plain peripheral strobe
    localparam int SL_KEYMUX = 2, SL_CNTR0 = 12, SL_SHARED = 13, SL_ADC = 14;
    localparam int SL_PER0   = 3;           // first peripheral slot
    localparam int N_PLAIN   = 9;           // strobes 0..8 map to slots 3..11
    localparam int PE_TMRY   = 9, PE_ADC = 10;

    // vector low address: two bytes per priority level, counting down
    function automatic logic [VEC_W-1:0] vec_of(input logic [CODE_W-1:0] c);
        return VEC_TOP - {{(VEC_W-CODE_W-1){1'b0}}, c, 1'b0};
    endfunction
endpackage

// File: rtl/icu_sync.sv
// Multi-stage synchronizer for asynchronous pins.
// Assumes pins idle high; stages reset to 1.
module icu_sync #(
    parameter int W     = 1,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [DEPTH-1:0][W-1:0] stg;

    // shift the pin value through the stages
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= '1;
        else        stg <= {stg[DEPTH-2:0], din};
    end

    assign dout = stg[DEPTH-1];
endmodule

// File: rtl/icu_edge_det.sv
// Rising-edge detector on already-polarized levels.
// Previous value resets to 1 so no edge is seen coming out of reset.
module icu_edge_det #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    // remember the level of the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_chk
            // a level must drop before it can rise again (R8)
            assert_single_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
                rise_o[gi] |=> !rise_o[gi]);
        end
    endgenerate
endmodule

// File: rtl/icu_prio_enc.sv
// Fixed-priority encoder: the lowest set index wins.
// Purely combinational.
module icu_prio_enc #(
    parameter int W  = 8,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  req_i,
    output logic          valid_o,
    output logic [IW-1:0] idx_o
);
    // scan from the top so the lowest index is written last
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                valid_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/icu_vec_ctrl.sv
// Prioritized vectored interrupt controller (top).
// Latches per-slot requests from pin edges and peripheral strobes, gates them
// with enables and a disable flag, and holds the winning vector until ack.
// Assumes peripheral strobes and brk_i are one cycle wide and synchronous.
module icu_vec_ctrl
    import icu_pkg::*;
#(
    parameter int N_KEY      = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_EXT-1:0]    ext_pin_i,
    input  logic [N_KEY-1:0]    key_pin_i,
    input  logic [N_PERIPH-1:0] periph_evt_i,
    input  logic                brk_i,
    input  logic                reg_wr_i,
    input  logic [1:0]          reg_addr_i,
    input  logic [15:0]         reg_wdata_i,
    output logic [15:0]         reg_rdata_o,
    output logic                irq_o,
    output logic [VEC_W-1:0]    vec_o,
    input  logic                ack_i
);
    localparam int IW = $clog2(N_SLOT);
    localparam logic [1:0] A_EN = 2'd0, A_REQ = 2'd1, A_CFG = 2'd2, A_FLAG = 2'd3;
    localparam int CFG_KEYSEL = 8, CFG_SHSEL = 9;

    logic [N_SLOT-1:0] en_q, req_q, hw_set, cand, sw_keep, ack_clr;
    logic [N_EXT-1:0]  edge_sel_q, s_ext, pol, lvl, rise;
    logic [N_KEY-1:0]  s_key;
    logic              key_sel_q, sh_sel_q, iflag_q;
    logic              pend_q, reset_pend_q, brk_pend_q;
    logic [CODE_W-1:0] code_q, code_nxt;
    logic              m_valid, any_src, take_ack;
    logic [IW-1:0]     m_idx;
    logic              wdata_unused;

    assign wdata_unused = ^reg_wdata_i[15:10] ^ ^reg_wdata_i[7:5];

    icu_sync #(.W(N_EXT), .DEPTH(SYNC_DEPTH)) u_sync_ext (
        .clk(clk), .rst_n(rst_n), .din(ext_pin_i), .dout(s_ext));
    icu_sync #(.W(N_KEY), .DEPTH(SYNC_DEPTH)) u_sync_key (
        .clk(clk), .rst_n(rst_n), .din(key_pin_i), .dout(s_key));

    // fold edge polarity and source selection into one level per detector
    always_comb begin
        pol                = edge_sel_q ~^ s_ext;  // 1 = active level
        lvl                = pol;
        lvl[EX_INT2]       = key_sel_q ? ~(&s_key) : pol[EX_INT2];
        lvl[EX_CNTR1]      = sh_sel_q & pol[EX_CNTR1];
    end

    icu_edge_det #(.W(N_EXT)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .rise_o(rise));

    // map edges and strobes onto request slots
    always_comb begin
        hw_set                                 = '0;
        hw_set[EX_INT0]                        = rise[EX_INT0];
        hw_set[EX_INT1]                        = rise[EX_INT1];
        hw_set[SL_KEYMUX]                      = rise[EX_INT2];
        hw_set[SL_PER0 +: N_PLAIN]             = periph_evt_i[N_PLAIN-1:0];
        hw_set[SL_CNTR0]                       = rise[EX_CNTR0];
        hw_set[SL_SHARED]                      = rise[EX_CNTR1] | (~sh_sel_q & periph_evt_i[PE_TMRY]);
        hw_set[SL_ADC]                         = periph_evt_i[PE_ADC];
    end

    assign take_ack = pend_q & ack_i;
    assign sw_keep  = (reg_wr_i && reg_addr_i == A_REQ) ? reg_wdata_i[N_SLOT-1:0] : '1;

    // one-hot clear of the accepted maskable slot
    always_comb begin
        ack_clr = '0;
        if (take_ack && code_q != CODE_RESET && code_q != CODE_BRK)
            ack_clr[IW'(code_q - 1'b1)] = 1'b1;
    end

    // request latches: hardware set wins over software and ack clears
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= (req_q & sw_keep & ~ack_clr) | hw_set;
    end

    // software-visible enables and configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q       <= '0;
            edge_sel_q <= '0;
            key_sel_q  <= 1'b0;
            sh_sel_q   <= 1'b0;
        end else if (reg_wr_i && reg_addr_i == A_EN) begin
            en_q <= reg_wdata_i[N_SLOT-1:0];
        end else if (reg_wr_i && reg_addr_i == A_CFG) begin
            edge_sel_q <= reg_wdata_i[N_EXT-1:0];
            key_sel_q  <= reg_wdata_i[CFG_KEYSEL];
            sh_sel_q   <= reg_wdata_i[CFG_SHSEL];
        end
    end

    // disable flag: set by acceptance, otherwise software-written
    always_ff @(posedge clk) begin
        if (!rst_n)                                iflag_q <= 1'b1;
        else if (take_ack)                         iflag_q <= 1'b1;
        else if (reg_wr_i && reg_addr_i == A_FLAG) iflag_q <= reg_wdata_i[0];
    end

    // unmaskable pending sources
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_pend_q <= 1'b1;
            brk_pend_q   <= 1'b0;
        end else begin
            if (take_ack && code_q == CODE_RESET) reset_pend_q <= 1'b0;
            if (brk_i)                             brk_pend_q   <= 1'b1;
            else if (take_ack && code_q == CODE_BRK) brk_pend_q <= 1'b0;
        end
    end

    assign cand = req_q & en_q & {N_SLOT{~iflag_q}};

    icu_prio_enc #(.W(N_SLOT)) u_prio (
        .req_i(cand), .valid_o(m_valid), .idx_o(m_idx));

    // choose the next code: reset, then maskable slots, then break
    always_comb begin
        any_src  = reset_pend_q | m_valid | brk_pend_q;
        if (reset_pend_q)  code_nxt = CODE_RESET;
        else if (m_valid)  code_nxt = CODE_W'(m_idx) + 1'b1;
        else               code_nxt = CODE_BRK;
    end

    // commit a winner and hold it until the CPU acknowledges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            code_q <= CODE_RESET;
        end else if (take_ack) begin
            pend_q <= 1'b0;
        end else if (!pend_q && any_src) begin
            pend_q <= 1'b1;
            code_q <= code_nxt;
        end
    end

    assign irq_o = pend_q;
    assign vec_o = vec_of(code_q);

    // register read mux
    always_comb begin
        unique case (reg_addr_i)
            A_EN:    reg_rdata_o = 16'(en_q);
            A_REQ:   reg_rdata_o = 16'(req_q);
            A_CFG:   reg_rdata_o = 16'({sh_sel_q, key_sel_q, 3'b000, edge_sel_q});
            default: reg_rdata_o = 16'(iflag_q);
        endcase
    end

    // presented vector is held until acknowledged (R7)
    assert_vec_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_i) |=> (irq_o && $stable(vec_o)));

    // acceptance drops the request line and masks further slots (R6)
    assert_ack_masks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack_i) |=> (!irq_o && iflag_q));

    // a maskable slot is only committed while the flag was clear (R2)
    assert_flag_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pend_q) && code_q != CODE_RESET && code_q != CODE_BRK) |-> !$past(iflag_q));

    // break is never blocked once nothing else competes (R5)
    assert_brk_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_pend_q && !pend_q && !reset_pend_q && !m_valid) |=> (pend_q && code_q == CODE_BRK));

    genvar gs;
    generate
        for (gs = 0; gs < N_SLOT; gs++) begin : g_req_chk
            // only a hardware event can raise a request bit (R3)
            assert_no_sw_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(req_q[gs]) |-> $past(hw_set[gs]));
        end
    endgenerate
endmodule

// File: tb/icu_vec_ctrl_tb.sv
// Self-checking bench: random strobe bursts plus directed pin sequences.
module icu_vec_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ext_pin = '1;
    logic [7:0]  key_pin = '1;
    logic [10:0] periph = '0;
    logic        brk = 1'b0, wr = 1'b0, ack = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0, rdata, vec;
    logic        irq;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    icu_vec_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin), .key_pin_i(key_pin),
        .periph_evt_i(periph), .brk_i(brk), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .vec_o(vec),
        .ack_i(ack));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic ack_pulse();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic expect_req(input logic [14:0] exp, input string tag);
        logic [15:0] d;
        reg_read(2'd1, d);
        chk(d[14:0] == exp, tag, d, exp);
    endtask

    function automatic logic [15:0] slot_vec(input int k);
        return 16'hFFFA - 16'(2 * k);
    endfunction

    function automatic logic [14:0] slots_of(input logic [10:0] p);
        logic [14:0] s = '0;
        for (int i = 0; i < 9; i++) s[3+i] = p[i];
        s[13] = p[9];
        s[14] = p[10];
        return s;
    endfunction

    function automatic int lowest(input logic [14:0] x);
        for (int i = 0; i < 15; i++) if (x[i]) return i;
        return -1;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] d;
        logic [14:0] exp_req, en;
        logic [10:0] pm;
        void'($urandom(32'h1C5));

        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        chk(irq == 1'b1 && vec == 16'hFFFC, "R1 reset vector", {irq, vec}, {1'b1, 16'hFFFC});
        reg_read(2'd0, d); chk(d == 0, "R1 enable reset", d, 0);
        reg_read(2'd1, d); chk(d == 0, "R1 request reset", d, 0);
        reg_read(2'd2, d); chk(d == 0, "R1 config reset", d, 0);
        reg_read(2'd3, d); chk(d == 1, "R1 flag reset", d, 1);
        tick(2);
        chk(vec == 16'hFFFC, "R7 reset vector held", vec, 16'hFFFC);
        ack_pulse();
        chk(irq == 1'b0, "R6 irq drops after ack", irq, 0);

        // R2: flag blocks an enabled request until cleared
        reg_write(2'd0, 16'h0008);
        periph = 11'h001; tick(1); periph = '0;
        tick(3);
        chk(irq == 1'b0, "R2 flag masks", irq, 0);
        expect_req(15'h0008, "R12 serial rx slot latched");
        reg_write(2'd3, 16'h0000);
        tick(2);
        chk(irq && vec == slot_vec(3), "R2 taken when flag clear", vec, slot_vec(3));
        ack_pulse();
        chk(irq == 1'b0, "R6 irq low", irq, 0);
        expect_req(15'h0000, "R6 accepted bit cleared");
        reg_read(2'd3, d); chk(d == 1, "R6 flag set", d, 1);

        // R3: software can clear but never set requests
        reg_write(2'd0, 16'h0000);
        periph = 11'h014; tick(1); periph = '0;   // slots 5 and 7
        tick(2);
        reg_write(2'd1, 16'hFFFF);
        expect_req(15'h00A0, "R3 write ones keeps");
        reg_write(2'd1, ~16'h0020);
        expect_req(15'h0080, "R3 write zero clears one");
        reg_write(2'd1, 16'h0000);
        expect_req(15'h0000, "R3 write zero clears all");

        // R4 / R7 / R12: random bursts against random enables
        for (int it = 0; it < 40; it++) begin
            en = 15'($urandom);
            pm = 11'($urandom);
            reg_write(2'd0, {1'b0, en});
            periph = pm; tick(1); periph = '0;
            tick(2);
            exp_req = slots_of(pm);
            expect_req(exp_req, "R12 strobe-to-slot map");
            for (int k = 0; k < 16; k++) begin
                int w;
                reg_write(2'd3, 16'h0000);
                tick(2);
                w = lowest(exp_req & en);
                if (w < 0) begin
                    chk(irq == 1'b0, "R2 nothing enabled", irq, 0);
                    break;
                end
                chk(irq && vec == slot_vec(w), "R4 priority winner", vec, slot_vec(w));
                tick(2);
                chk(irq && vec == slot_vec(w), "R7 vector stable", vec, slot_vec(w));
                ack_pulse();
                exp_req[w] = 1'b0;
                chk(irq == 1'b0, "R6 irq low after ack", irq, 0);
                expect_req(exp_req, "R4 losers stay latched");
            end
            reg_write(2'd1, 16'h0000);
        end
        reg_write(2'd0, 16'h0000);

        // R5: break alone, with flag set and nothing enabled
        brk = 1'b1; tick(1); brk = 1'b0;
        tick(2);
        chk(irq && vec == 16'hFFDC, "R5 break unmaskable", vec, 16'hFFDC);
        ack_pulse();
        chk(irq == 1'b0, "R5 break accepted", irq, 0);
        // R5: break loses to a maskable slot, then runs with flag set
        reg_write(2'd0, 16'h4000);
        reg_write(2'd3, 16'h0000);
        periph = 11'h400; brk = 1'b1; tick(1); periph = '0; brk = 1'b0;
        tick(2);
        chk(irq && vec == 16'hFFDE, "R5 break lowest priority", vec, 16'hFFDE);
        ack_pulse();
        tick(2);
        chk(irq && vec == 16'hFFDC, "R5 break after flag set", vec, 16'hFFDC);
        ack_pulse();
        reg_write(2'd0, 16'h0000);

        // R8: INT0 falling then rising edge
        ext_pin[0] = 1'b0; tick(5);
        expect_req(15'h0001, "R8 falling edge INT0");
        reg_write(2'd1, 16'h0000);
        reg_write(2'd2, 16'h0001);
        tick(2);
        expect_req(15'h0000, "R11 no fire when level inactive");
        ext_pin[0] = 1'b1; tick(5);
        expect_req(15'h0001, "R8 rising edge INT0");
        reg_write(2'd1, 16'h0000);
        ext_pin[0] = 1'b0; tick(5);
        expect_req(15'h0000, "R8 falling ignored in rising mode");
        // R11: switch to falling while pin is low
        reg_write(2'd2, 16'h0000);
        tick(2);
        expect_req(15'h0001, "R11 edge-select change fires");
        reg_write(2'd1, 16'h0000);
        ext_pin[0] = 1'b1; tick(5);
        expect_req(15'h0000, "R8 rising ignored in falling mode");

        // R9: key input vs INT2 on slot 2
        key_pin[5] = 1'b0; tick(5);
        expect_req(15'h0000, "R9 keys ignored when INT2 selected");
        key_pin[5] = 1'b1; tick(5);
        reg_write(2'd2, 16'h0100);
        tick(2);
        expect_req(15'h0000, "R9 select change with keys high");
        key_pin[5] = 1'b0; tick(5);
        expect_req(15'h0004, "R9 key AND falling");
        reg_write(2'd1, 16'h0000);
        ext_pin[2] = 1'b0; tick(5);
        expect_req(15'h0000, "R9 INT2 ignored when keys selected");
        ext_pin[2] = 1'b1; key_pin[5] = 1'b1; tick(5);
        reg_write(2'd2, 16'h0000);
        tick(2);
        expect_req(15'h0000, "R9 back to INT2 quietly");

        // R10: timer Y vs CNTR1 on slot 13
        periph = 11'h200; tick(1); periph = '0; tick(2);
        expect_req(15'h2000, "R10 timer Y strobe");
        reg_write(2'd1, 16'h0000);
        ext_pin[4] = 1'b0; tick(5);
        expect_req(15'h0000, "R10 CNTR1 ignored when timer Y selected");
        reg_write(2'd2, 16'h0200);
        tick(2);
        expect_req(15'h2000, "R11 source-select change fires");
        reg_write(2'd1, 16'h0000);
        ext_pin[4] = 1'b1; tick(5);
        ext_pin[4] = 1'b0; tick(5);
        expect_req(15'h2000, "R10 CNTR1 falling edge");
        reg_write(2'd1, 16'h0000);
        periph = 11'h200; tick(1); periph = '0; tick(2);
        expect_req(15'h0000, "R10 timer Y ignored when CNTR1 selected");

        // R8: CNTR0 and INT1 map to slots 12 and 1
        ext_pin[3] = 1'b0; ext_pin[1] = 1'b0; tick(5);
        expect_req(15'h1002, "R8 INT1 and CNTR0 slots");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule